// File: doc/BRIEF.md
# Bit-Field Manipulation Unit

A purely combinational 32-bit execution unit for the bit-manipulation group of an integer pipeline. In one datapath it extracts or inserts a bit field, swaps the two bytes inside each halfword, sign-extends a byte or a halfword, counts leading zeros or leading ones, and rotates right by an immediate amount or by an amount held in a register.

The issuing stage drives two source operands, a 5-bit position field, a 5-bit size field and a 4-bit operation code. The result appears on `result` in the same cycle. For insert, the old destination value arrives on `rtVal`, so the unit merges the field without any extra read port. Decode, register access and exceptions belong to the surrounding pipeline.

Top module: `bitfield_unit`

## Requirements
- R1: With opSel=0 (extract), result holds rsVal[posField+len-1 : posField] right-justified and zero-extended, where len = sizeField+1 (1 to 32). Bits that would come from above bit 31 read as zero.
- R2: With opSel=1 (insert), sizeField gives the top bit index msb of the field. Bits msb..posField of rtVal are replaced by rsVal[msb-posField:0], and every other bit of rtVal passes through. When msb < posField, result equals rtVal.
- R3: With opSel=2 (halfword byte swap), result is {rsVal[23:16], rsVal[31:24], rsVal[7:0], rsVal[15:8]}.
- R4: With opSel=3, result is rsVal[7:0] with rsVal[7] copied into bits 31:8. With opSel=4, result is rsVal[15:0] with rsVal[15] copied into bits 31:16.
- R5: With opSel=5, result is the number of consecutive zero bits counting down from bit 31 (0 to 32). An all-zero operand gives 32.
- R6: With opSel=6, result is the number of consecutive one bits counting down from bit 31 (0 to 32). An all-ones operand gives 32.
- R7: With opSel=7 (rotate by immediate), result is rsVal rotated right by posField, so that result bit i equals rsVal bit (i+posField) mod 32.
- R8: With opSel=8 (rotate by register), the rotate amount is rtVal[4:0]. Bits 31:5 of rtVal have no effect on the result.
- R9: A rotate amount of zero, by either the immediate or the register, returns rsVal unchanged.
- R10: opSel codes 9 to 15 drive result to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opSel | input | 4 | Operation code (0 extract, 1 insert, 2 byte swap, 3 byte sign-extend, 4 halfword sign-extend, 5 zeros count, 6 ones count, 7 rotate immediate, 8 rotate register) |
| rsVal | input | 32 | Primary source operand |
| rtVal | input | 32 | Old destination value for insert, rotate amount for register rotate |
| posField | input | 5 | Field position for extract and insert, amount for immediate rotate |
| sizeField | input | 5 | Length minus one for extract, top bit index for insert |
| result | output | 32 | Operation result |

## Verification
The bench targets fields that touch bit 0 and fields that end exactly at bit 31. A wrong mask there either drops the top bit of the field or lets bits from outside it leak in. It drives full-width fields (length 32, or msb 31 with position 0), where an off-by-one in the mask shift gives zero or wraps the mask. The count operations get all-zero, all-ones and single-bit operands, so a counter that saturates at 31 or picks the wrong end of the word is caught. Rotation is exercised at amounts 0, 1 and 31, and with garbage in rtVal[31:5], which exposes a rotator that shifts instead of wrapping or that reads upper amount bits.

// File: rtl/bitfield_pkg.sv
package bitfield_pkg;

  typedef enum logic [3:0] {
    OP_EXTRACT  = 4'd0,
    OP_INSERT   = 4'd1,
    OP_SWAPHALF = 4'd2,
    OP_SEXTBYTE = 4'd3,
    OP_SEXTHALF = 4'd4,
    OP_CNTZERO  = 4'd5,
    OP_CNTONE   = 4'd6,
    OP_ROTIMM   = 4'd7,
    OP_ROTREG   = 4'd8
  } bfOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic fieldExt;
    logic fieldIns;
    logic swapHalf;
    logic signExt;
    logic sextHalf;
    logic leadCount;
    logic countOnes;
    logic rotate;
    logic rotByReg;
  } bfStrobe_t;

endpackage

// File: rtl/bitfield_ctrl.sv
module bitfield_ctrl
  import bitfield_pkg::*;
(
  input  logic [3:0] opSel,
  output bfStrobe_t  strobe
);

  always_comb begin
    strobe = '0;
    case (opSel)
      OP_EXTRACT:  strobe.fieldExt  = 1'b1;
      OP_INSERT:   strobe.fieldIns  = 1'b1;
      OP_SWAPHALF: strobe.swapHalf  = 1'b1;
      OP_SEXTBYTE: strobe.signExt   = 1'b1;
      OP_SEXTHALF: begin
        strobe.signExt  = 1'b1;
        strobe.sextHalf = 1'b1;
      end
      OP_CNTZERO:  strobe.leadCount = 1'b1;
      OP_CNTONE: begin
        strobe.leadCount = 1'b1;
        strobe.countOnes = 1'b1;
      end
      OP_ROTIMM:   strobe.rotate    = 1'b1;
      OP_ROTREG: begin
        strobe.rotate   = 1'b1;
        strobe.rotByReg = 1'b1;
      end
      default:     strobe = '0;
    endcase
  end

endmodule

// File: rtl/bitfield_field.sv
module bitfield_field #(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] rsVal,
  input  logic [DATA_W-1:0] oldVal,
  input  logic [SH_W-1:0]   posField,
  input  logic [SH_W-1:0]   sizeField,
  output logic [DATA_W-1:0] extOut,
  output logic [DATA_W-1:0] insOut
);

  localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

  logic [SH_W-1:0]   topGap;
  logic [DATA_W-1:0] lowMask;
  logic [DATA_W-1:0] insMask;
  logic [DATA_W-1:0] shiftedDown;
  logic [DATA_W-1:0] shiftedUp;

  // ones in bits sizeField..0
  assign topGap      = SH_W'(DATA_W - 1) - sizeField;
  assign lowMask     = ALL_ONES >> topGap;
  assign shiftedDown = rsVal >> posField;
  assign shiftedUp   = rsVal << posField;
  // ones in bits sizeField..posField, empty when sizeField < posField
  assign insMask     = lowMask & (ALL_ONES << posField);

  assign extOut = shiftedDown & lowMask;
  assign insOut = (oldVal & ~insMask) | (shiftedUp & insMask);

endmodule

// File: rtl/bitfield_leadcount.sv
module bitfield_leadcount #(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] srcVal,
  input  logic              countOnes,
  output logic [CNT_W-1:0]  count
);

  logic [DATA_W-1:0] probe;
  logic              found;

  assign probe = countOnes ? ~srcVal : srcVal;

  always_comb begin
    count = CNT_W'(DATA_W);
    found = 1'b0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (!found && probe[i]) begin
        count = CNT_W'(DATA_W - 1 - i);
        found = 1'b1;
      end
    end
  end

endmodule

// File: rtl/bitfield_rotator.sv
module bitfield_rotator #(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] srcVal,
  input  logic [SH_W-1:0]   amount,
  output logic [DATA_W-1:0] rotOut
);

  logic [DATA_W-1:0] stage [SH_W+1];

  assign stage[0] = srcVal;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = amount[k]
                      ? {stage[k][STEP-1:0], stage[k][DATA_W-1:STEP]}
                      : stage[k];
  end

  assign rotOut = stage[SH_W];

endmodule

// File: rtl/bitfield_datapath.sv
module bitfield_datapath
  import bitfield_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W),
  localparam int CNT_W = SH_W + 1,
  localparam int HALVES = DATA_W / 16
) (
  input  bfStrobe_t         strobe,
  input  logic [DATA_W-1:0] rsVal,
  input  logic [DATA_W-1:0] rtVal,
  input  logic [SH_W-1:0]   posField,
  input  logic [SH_W-1:0]   sizeField,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] extOut;
  logic [DATA_W-1:0] insOut;
  logic [DATA_W-1:0] swapOut;
  logic [DATA_W-1:0] sextOut;
  logic [DATA_W-1:0] rotOut;
  logic [CNT_W-1:0]  countOut;
  logic [SH_W-1:0]   rotAmount;

  bitfield_field #(.DATA_W(DATA_W)) u_field (
    .rsVal     (rsVal),
    .oldVal    (rtVal),
    .posField  (posField),
    .sizeField (sizeField),
    .extOut    (extOut),
    .insOut    (insOut)
  );

  bitfield_leadcount #(.DATA_W(DATA_W)) u_count (
    .srcVal    (rsVal),
    .countOnes (strobe.countOnes),
    .count     (countOut)
  );

  assign rotAmount = strobe.rotByReg ? rtVal[SH_W-1:0] : posField;

  bitfield_rotator #(.DATA_W(DATA_W)) u_rot (
    .srcVal (rsVal),
    .amount (rotAmount),
    .rotOut (rotOut)
  );

  for (genvar h = 0; h < HALVES; h++) begin : g_swap
    assign swapOut[16*h +: 16] = {rsVal[16*h +: 8], rsVal[16*h+8 +: 8]};
  end

  assign sextOut = strobe.sextHalf
                 ? {{(DATA_W-16){rsVal[15]}}, rsVal[15:0]}
                 : {{(DATA_W-8){rsVal[7]}},  rsVal[7:0]};

  always_comb begin
    if (strobe.fieldExt)       result = extOut;
    else if (strobe.fieldIns)  result = insOut;
    else if (strobe.swapHalf)  result = swapOut;
    else if (strobe.signExt)   result = sextOut;
    else if (strobe.leadCount) result = DATA_W'(countOut);
    else if (strobe.rotate)    result = rotOut;
    else                       result = '0;
  end

endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bitfield_pkg::*;
(
  input  logic [3:0]  opSel,
  input  logic [31:0] rsVal,
  input  logic [31:0] rtVal,
  input  logic [4:0]  posField,
  input  logic [4:0]  sizeField,
  output logic [31:0] result
);

  bfStrobe_t strobe;

  bitfield_ctrl u_ctrl (
    .opSel  (opSel),
    .strobe (strobe)
  );

  bitfield_datapath #(.DATA_W(32)) u_dp (
    .strobe    (strobe),
    .rsVal     (rsVal),
    .rtVal     (rtVal),
    .posField  (posField),
    .sizeField (sizeField),
    .result    (result)
  );

endmodule

// File: rtl/bitfield_unit_check.sv
module bitfield_unit_check (
  input logic [3:0]  opSel,
  input logic [31:0] rsVal,
  input logic [31:0] rtVal,
  input logic [4:0]  posField,
  input logic [4:0]  sizeField,
  input logic [31:0] result
);

  logic [31:0] belowPos;
  assign belowPos = (32'h1 << posField) - 32'h1;

  always_comb begin
    if (opSel == 4'd1)
      assert_ins_low_kept_R2: assert (((result ^ rtVal) & belowPos) == 32'h0)
        else $error("insert disturbed bits below the field");
    if (opSel == 4'd2)
      assert_swap_bytes_R3: assert (result[31:24] == rsVal[23:16] && result[7:0] == rsVal[15:8])
        else $error("byte swap order wrong");
    if (opSel == 4'd3)
      assert_sext_byte_R4: assert (result[7:0] == rsVal[7:0] && (result[31:8] == 24'h0 || result[31:8] == 24'hFFFFFF) && result[8] == rsVal[7])
        else $error("byte sign extension wrong");
    if (opSel == 4'd5)
      assert_clz_range_R5: assert (result <= 32'd32 && ((result == 32'd32) == (rsVal == 32'h0)))
        else $error("zeros count out of range");
    if (opSel == 4'd6)
      assert_clo_range_R6: assert (result <= 32'd32 && ((result == 32'd32) == (rsVal == 32'hFFFFFFFF)))
        else $error("ones count out of range");
    if (opSel == 4'd8 && rtVal[4:0] == 5'd0)
      assert_rot_zero_R9: assert (result == rsVal)
        else $error("zero rotate changed operand");
    if (opSel > 4'd8)
      assert_unused_zero_R10: assert (result == 32'h0)
        else $error("unused code gave nonzero result");
  end

endmodule

bind bitfield_unit bitfield_unit_check u_check (
  .opSel     (opSel),
  .rsVal     (rsVal),
  .rtVal     (rtVal),
  .posField  (posField),
  .sizeField (sizeField),
  .result    (result)
);

// File: tb/bitfield_unit_test.sv
module bitfield_unit_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  opSel = 4'd15;
  logic [31:0] rsVal = '0;
  logic [31:0] rtVal = '0;
  logic [4:0]  posField = '0;
  logic [4:0]  sizeField = '0;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitfield_unit uut (
    .opSel     (opSel),
    .rsVal     (rsVal),
    .rtVal     (rtVal),
    .posField  (posField),
    .sizeField (sizeField),
    .result    (result)
  );

  function automatic logic [31:0] refModel(input logic [3:0] op, input logic [31:0] a,
                                           input logic [31:0] b, input int p, input int s);
    logic [31:0] r;
    int amt;
    int n;
    r = '0;
    case (op)
      4'd0: for (int i = 0; i < 32; i++) if (i <= s && p + i < 32) r[i] = a[p+i];
      4'd1: for (int i = 0; i < 32; i++) r[i] = (i >= p && i <= s) ? a[i-p] : b[i];
      4'd2: r = {a[23:16], a[31:24], a[7:0], a[15:8]};
      4'd3: for (int i = 0; i < 32; i++) r[i] = (i < 8) ? a[i] : a[7];
      4'd4: for (int i = 0; i < 32; i++) r[i] = (i < 16) ? a[i] : a[15];
      4'd5, 4'd6: begin
        n = 0;
        for (int i = 31; i >= 0; i--) begin
          if (a[i] != (op == 4'd6)) break;
          n++;
        end
        r = 32'(n);
      end
      4'd7, 4'd8: begin
        amt = (op == 4'd7) ? p : int'(b[4:0]);
        for (int i = 0; i < 32; i++) r[i] = a[(i + amt) % 32];
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic applyCheck(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                            input int p, input int s, input logic [31:0] exp, input string tag);
    @(posedge clk);
    opSel = op; rsVal = a; rtVal = b; posField = 5'(p); sizeField = 5'(s);
    @(negedge clk);
    checks++;
    if (result !== exp) begin
      errors++;
      $display("FAIL %s op=%0d rs=%h rt=%h p=%0d s=%0d actual=%h expected=%h",
               tag, op, a, b, p, s, result, exp);
    end
  endtask

  task automatic runRef(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                        input int p, input int s, input string tag);
    applyCheck(op, a, b, p, s, refModel(op, a, b, p, s), tag);
  endtask

  task automatic testIdle();
    applyCheck(4'd15, 32'hDEADBEEF, 32'h12345678, 3, 7, 32'h0, "R10 idle");
    for (int c = 9; c < 16; c++)
      applyCheck(4'(c), 32'hFFFFFFFF, 32'hFFFFFFFF, 31, 31, 32'h0, "R10");
  endtask

  task automatic testExtract();
    applyCheck(4'd0, 32'hABCD1234, 0, 0, 7, 32'h00000034, "R1 p0");
    applyCheck(4'd0, 32'hABCD1234, 0, 28, 3, 32'h0000000A, "R1 top");
    applyCheck(4'd0, 32'hABCD1234, 0, 0, 31, 32'hABCD1234, "R1 full");
    applyCheck(4'd0, 32'h80000000, 0, 31, 0, 32'h1, "R1 bit31");
    for (int k = 0; k < 40; k++) begin
      int p = $urandom_range(0, 31);
      runRef(4'd0, $urandom, $urandom, p, $urandom_range(0, 31 - p), "R1 rand");
    end
  endtask

  task automatic testInsert();
    applyCheck(4'd1, 32'h000000FF, 32'h12345678, 8, 15, 32'h1234FF78, "R2 mid");
    applyCheck(4'd1, 32'h0000000A, 32'hFFFFFFFF, 28, 31, 32'hAFFFFFFF, "R2 top");
    applyCheck(4'd1, 32'hCAFEF00D, 32'h0, 0, 31, 32'hCAFEF00D, "R2 full");
    applyCheck(4'd1, 32'hFFFFFFFF, 32'h5A5A5A5A, 10, 4, 32'h5A5A5A5A, "R2 empty");
    for (int k = 0; k < 40; k++) begin
      int p = $urandom_range(0, 31);
      runRef(4'd1, $urandom, $urandom, p, $urandom_range(p, 31), "R2 rand");
    end
  endtask

  task automatic testSwapSext();
    applyCheck(4'd2, 32'h11223344, 0, 0, 0, 32'h22114433, "R3");
    applyCheck(4'd3, 32'h00000080, 0, 0, 0, 32'hFFFFFF80, "R4 byte neg");
    applyCheck(4'd3, 32'hFFFFFF7F, 0, 0, 0, 32'h0000007F, "R4 byte pos");
    applyCheck(4'd4, 32'h00008001, 0, 0, 0, 32'hFFFF8001, "R4 half neg");
    applyCheck(4'd4, 32'hFFFF7FFF, 0, 0, 0, 32'h00007FFF, "R4 half pos");
    for (int k = 0; k < 10; k++) begin
      logic [31:0] v = $urandom;
      runRef(4'd2, v, 0, 0, 0, "R3 rand");
      runRef(4'd3, v, 0, 0, 0, "R4 rand");
      runRef(4'd4, v, 0, 0, 0, "R4 rand");
    end
  endtask

  task automatic testCount();
    applyCheck(4'd5, 32'h0, 0, 0, 0, 32'd32, "R5 zero");
    applyCheck(4'd5, 32'h80000000, 0, 0, 0, 32'd0, "R5 msb");
    applyCheck(4'd5, 32'h00000001, 0, 0, 0, 32'd31, "R5 lsb");
    applyCheck(4'd6, 32'hFFFFFFFF, 0, 0, 0, 32'd32, "R6 ones");
    applyCheck(4'd6, 32'h7FFFFFFF, 0, 0, 0, 32'd0, "R6 msb0");
    applyCheck(4'd6, 32'hFFFFFFFE, 0, 0, 0, 32'd31, "R6 lsb0");
    for (int k = 0; k < 20; k++) begin
      logic [31:0] v = $urandom >> $urandom_range(0, 31);
      runRef(4'd5, v, 0, 0, 0, "R5 rand");
      runRef(4'd6, ~v, 0, 0, 0, "R6 rand");
    end
  endtask

  task automatic testRotate();
    applyCheck(4'd7, 32'h12345678, 0, 0, 0, 32'h12345678, "R9 imm");
    applyCheck(4'd7, 32'h00000001, 0, 1, 0, 32'h80000000, "R7 by1");
    applyCheck(4'd7, 32'h80000001, 0, 31, 0, 32'h00000003, "R7 by31");
    applyCheck(4'd8, 32'h12345678, 32'hFFFFFFE0, 0, 9, 32'h12345678, "R9 reg");
    applyCheck(4'd8, 32'h000000FF, 32'hABCDEF04, 17, 0, 32'hF000000F, "R8 upper");
    for (int k = 0; k < 20; k++) begin
      runRef(4'd7, $urandom, $urandom, $urandom_range(0, 31), 0, "R7 rand");
      runRef(4'd8, $urandom, $urandom, $urandom_range(0, 31), 0, "R8 rand");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    testIdle();
    testExtract();
    testInsert();
    testSwapSext();
    testCount();
    testRotate();
    @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule